// File: doc/BRIEF.md
# Time-Interleaved Accumulate-and-Compare Unit

This block is a small accumulate-and-compare datapath whose single feedback loop has been cut into C register levels. The logic is shared by C independent threads. Each thread owns one accumulator value, and that value circulates around the loop. The threads take turns in a fixed rotation, one clock cycle each. A free-running slot counter names the thread that owns the current cycle. The sample on `in_sample` in that cycle belongs to that thread.

For one thread, a single update of the unsliced design takes C clock cycles. In the first level the sample is added to the thread's stored value. The next level compares the sum against a fixed limit. The last level subtracts the limit when the compare matched, and the value then goes back to the adder. Each result leaves the loop tagged with the index of its thread.

State is never held with a register enable. A thread that gets nothing to add simply recirculates its value. The configuration lives in the package: sample width, thread count (at least 3) and limit.

Top module: `csr_accum_top`

## Requirements
- R1: After reset `cur_slot` is 0. It then increases by one every clock cycle and returns from C-1 to 0.
- R2: The sample applied in a cycle belongs to thread `cur_slot` of that cycle. Its result is on the outputs exactly C cycles later, with `out_thread` equal to that slot.
- R3: Update rule for a thread with stored value A and sample S. Let sum = A + S, computed in SAMPLE_W+1 bits. If sum >= LIMIT, the new value is (sum - LIMIT) mod 2^SAMPLE_W and `out_hit` is 1. Otherwise the new value is sum mod 2^SAMPLE_W and `out_hit` is 0. `out_acc` shows the new value.
- R4: Threads are independent. A thread's results depend only on the samples given in its own slots.
- R5: A synchronous active-high reset clears every thread's stored value to 0. While reset is high, and for the first C cycles after it, `out_acc` is 0 and `out_hit` is 0.
- R6: In every cycle, `out_thread` equals `cur_slot`.
- R7: A zero sample leaves a thread's value unchanged when that value is below LIMIT, with `out_hit` 0. The value is kept by recirculating it through the loop.
- R8: A sum exactly equal to LIMIT gives `out_hit` = 1 and a value of 0. A sum of LIMIT-1 gives `out_hit` = 0.
- R9: A reset applied in the middle of operation discards nonzero thread values. The following results then start from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_sample | input | SAMPLE_W | Sample for the thread that owns the current cycle |
| cur_slot | output | TAG_W | Index of the thread that owns the current cycle |
| out_acc | output | SAMPLE_W | Updated stored value of thread `out_thread` |
| out_hit | output | 1 | The limit compare matched on that update |
| out_thread | output | TAG_W | Thread that produced `out_acc` and `out_hit` |

## Verification
A sample driven in cycle t reaches the outputs C rising edges later. It then appears in a cycle whose slot equals the slot in which the sample went in. The bench keeps one reference value per thread, indexed by slot. At every falling edge it first compares the outputs with the reference entry for the current slot. That entry still holds the thread's state from its sample C cycles earlier. Only after the comparison does the bench drive the new sample and update the entry. Reset checks are taken at a falling edge after at least one rising edge with reset high.

// File: rtl/csr_accum_pkg.sv
package csr_accum_pkg;

    // configuration of the datapath
    localparam int SAMPLE_W = 8;
    localparam int THREADS  = 3;     // loop levels and threads, at least 3
    localparam int LIMIT    = 200;

    // derived widths
    localparam int TAG_W = (THREADS > 1) ? $clog2(THREADS) : 1;
    localparam int SUM_W = SAMPLE_W + 1;

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [SUM_W-1:0]    sum_t;

    localparam sum_t LIMIT_V = sum_t'(LIMIT);

    // operation done by the logic in front of each loop level
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_CMP  = 2'd1,
        OP_PASS = 2'd2,
        OP_FOLD = 2'd3
    } level_op_e;

    // what travels from one loop level to the next
    typedef struct packed {
        tag_t tag;
        sum_t sum;
        logic hit;
    } lane_t;

    function automatic level_op_e op_of_level(input int lvl);
        if (lvl == 0)                 return OP_ADD;
        else if (lvl == 1)            return OP_CMP;
        else if (lvl == THREADS - 1)  return OP_FOLD;
        else                          return OP_PASS;
    endfunction

    function automatic tag_t next_slot(input tag_t s);
        return (s == tag_t'(THREADS - 1)) ? '0 : s + tag_t'(1);
    endfunction

    // level k holds, right after reset, the thread that entered k+1 cycles ago
    function automatic tag_t reset_tag(input int lvl);
        return tag_t'(THREADS - 1 - lvl);
    endfunction

    function automatic lane_t reset_lane(input int lvl);
        lane_t l;
        l.tag = reset_tag(lvl);
        l.sum = '0;
        l.hit = 1'b0;
        return l;
    endfunction

endpackage

// File: rtl/csr_slot_ctr.sv
module csr_slot_ctr
    import csr_accum_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output tag_t slot_o
);

    tag_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= next_slot(slot_q);
    end

    assign slot_o = slot_q;

    // R1
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_q == tag_t'(THREADS - 1)) |=> (slot_q == '0));

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q < tag_t'(THREADS));

endmodule

// File: rtl/csr_entry_stage.sv
module csr_entry_stage
    import csr_accum_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sum_t    acc_i,
    input  sample_t sample_i,
    input  tag_t    slot_i,
    output lane_t   lane_o
);

    lane_t nxt, lane_q;

    // level 0: add the sample to the value fed back from the last level
    always_comb begin
        nxt.tag = slot_i;
        nxt.sum = acc_i + sum_t'(sample_i);
        nxt.hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) lane_q <= reset_lane(0);
        else     lane_q <= nxt;
    end

    assign lane_o = lane_q;

endmodule

// File: rtl/csr_stage.sv
module csr_stage
    import csr_accum_pkg::*;
#(
    parameter int LVL = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_i,
    output lane_t lane_o
);

    localparam level_op_e OP = op_of_level(LVL);

    lane_t nxt, lane_q;

    generate
        if (OP == OP_CMP) begin : g_cmp
            always_comb begin
                nxt     = lane_i;
                nxt.hit = lane_i.hit | (lane_i.sum >= LIMIT_V);
            end
        end else if (OP == OP_FOLD) begin : g_fold
            sum_t reduced;
            always_comb begin
                reduced = lane_i.hit ? (lane_i.sum - LIMIT_V) : lane_i.sum;
                nxt     = lane_i;
                nxt.sum = {1'b0, reduced[SAMPLE_W-1:0]};
            end
        end else begin : g_pass
            always_comb nxt = lane_i;
        end
    endgenerate

    // every level is written every cycle; holding is by recirculation only
    always_ff @(posedge clk) begin
        if (rst) lane_q <= reset_lane(LVL);
        else     lane_q <= nxt;
    end

    assign lane_o = lane_q;

endmodule

// File: rtl/csr_accum_top.sv
module csr_accum_top
    import csr_accum_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic [TAG_W-1:0]    cur_slot,
    output logic [SAMPLE_W-1:0] out_acc,
    output logic                out_hit,
    output logic [TAG_W-1:0]    out_thread
);

    localparam int LAST = THREADS - 1;

    tag_t  slot;
    lane_t lane_q [THREADS];

    csr_slot_ctr u_slot (
        .clk    (clk),
        .rst    (rst),
        .slot_o (slot)
    );

    csr_entry_stage u_entry (
        .clk      (clk),
        .rst      (rst),
        .acc_i    (lane_q[LAST].sum),
        .sample_i (in_sample),
        .slot_i   (slot),
        .lane_o   (lane_q[0])
    );

    generate
        for (genvar k = 1; k < THREADS; k++) begin : g_lvl
            csr_stage #(.LVL(k)) u_stage (
                .clk    (clk),
                .rst    (rst),
                .lane_i (lane_q[k-1]),
                .lane_o (lane_q[k])
            );

            // R2
            level_order_chk: assert property (@(posedge clk) disable iff (rst)
                next_slot(lane_q[k].tag) == lane_q[k-1].tag);
        end
    endgenerate

    assign cur_slot   = slot;
    assign out_acc    = lane_q[LAST].sum[SAMPLE_W-1:0];
    assign out_hit    = lane_q[LAST].hit;
    assign out_thread = lane_q[LAST].tag;

    // R6
    out_tag_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_thread == cur_slot);

    // R2
    entry_tag_chk: assert property (@(posedge clk) disable iff (rst)
        next_slot(lane_q[0].tag) == cur_slot);

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_acc == '0 && !out_hit));

endmodule

// File: tb/csr_accum_top_tb.sv
module csr_accum_top_tb_top;
    import csr_accum_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MODV = 1 << SAMPLE_W;

    logic                clk;
    logic                rst;
    logic [SAMPLE_W-1:0] in_sample;
    logic [TAG_W-1:0]    cur_slot;
    logic [SAMPLE_W-1:0] out_acc;
    logic                out_hit;
    logic [TAG_W-1:0]    out_thread;

    int n_checks = 0;
    int n_fail   = 0;
    int m_acc [THREADS];
    bit m_hit [THREADS];
    int bslot;

    csr_accum_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_sample  (in_sample),
        .cur_slot   (cur_slot),
        .out_acc    (out_acc),
        .out_hit    (out_hit),
        .out_thread (out_thread)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < THREADS; i++) begin
            m_acc[i] = 0;
            m_hit[i] = 0;
        end
        bslot = 0;
    endtask

    // called at a falling edge: check outputs, drive sample, advance to next falling edge
    task automatic step(input int smp, input string req);
        int sum;
        chk(cur_slot == TAG_W'(bslot), "R1 slot", int'(cur_slot), bslot);
        chk(out_thread == TAG_W'(bslot), "R2/R6 tag", int'(out_thread), bslot);
        chk(out_acc == SAMPLE_W'(m_acc[bslot]), {req, " acc"}, int'(out_acc), m_acc[bslot]);
        chk(out_hit == m_hit[bslot], {req, " hit"}, int'(out_hit), int'(m_hit[bslot]));
        in_sample = SAMPLE_W'(smp);
        sum = m_acc[bslot] + smp;
        if (sum >= LIMIT) begin
            m_hit[bslot] = 1;
            m_acc[bslot] = (sum - LIMIT) % MODV;
        end else begin
            m_hit[bslot] = 0;
            m_acc[bslot] = sum % MODV;
        end
        bslot = (bslot + 1) % THREADS;
        @(negedge clk);
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        in_sample = '0;
        @(negedge clk);
        @(negedge clk);
        chk(out_acc == '0, {req, " acc in reset"}, int'(out_acc), 0);
        chk(out_hit == 1'b0, {req, " hit in reset"}, int'(out_hit), 0);
        chk(cur_slot == '0, "R1 slot in reset", int'(cur_slot), 0);
        rst = 1'b0;
        model_clear();
    endtask

    // R5: outputs stay zero for the first C cycles with zero samples
    task automatic test_reset_state();
        do_reset("R5");
        for (int i = 0; i < THREADS; i++) step(0, "R5");
        for (int i = 0; i < THREADS; i++) step(0, "R5");
    endtask

    // R3, R4: distinct per-thread patterns, with hits and wraps
    task automatic test_patterns();
        do_reset("R5");
        for (int r = 0; r < 20; r++)
            for (int t = 0; t < THREADS; t++)
                step((t == 0) ? 37 : (t == 1) ? 90 + r : 3 * r, "R3");
        for (int i = 0; i < THREADS; i++) step(0, "R3");
    endtask

    // R3: large samples force the mod-2^W truncation
    task automatic test_large();
        do_reset("R5");
        for (int r = 0; r < 8; r++)
            for (int t = 0; t < THREADS; t++) step(MODV - 1 - t, "R3");
        for (int i = 0; i < THREADS; i++) step(0, "R3");
    endtask

    // R8: sum one below the limit, then exactly at it
    task automatic test_boundary();
        do_reset("R5");
        for (int t = 0; t < THREADS; t++) step((t == 0) ? LIMIT - 1 : 0, "R8");
        chk(m_hit[0] == 0 && m_acc[0] == LIMIT - 1, "R8 model below", m_acc[0], LIMIT - 1);
        for (int t = 0; t < THREADS; t++) step((t == 0) ? 1 : 0, "R8");
        chk(m_hit[0] == 1 && m_acc[0] == 0, "R8 model at limit", m_acc[0], 0);
        for (int t = 0; t < THREADS; t++) step(0, "R8");
    endtask

    // R7: zero samples keep a value by recirculation
    task automatic test_hold();
        do_reset("R5");
        for (int t = 0; t < THREADS; t++) step((t == 1) ? 123 : 0, "R7");
        for (int r = 0; r < 6; r++)
            for (int t = 0; t < THREADS; t++) step(0, "R7");
        chk(m_acc[1] == 123, "R7 model hold", m_acc[1], 123);
    endtask

    // R4: only one thread receives data, the others must stay zero
    task automatic test_independence();
        do_reset("R5");
        for (int r = 0; r < 10; r++)
            for (int t = 0; t < THREADS; t++) step((t == THREADS - 1) ? 77 : 0, "R4");
        for (int t = 0; t < THREADS; t++) step(0, "R4");
    endtask

    // R9: reset in the middle of activity
    task automatic test_mid_reset();
        do_reset("R5");
        for (int r = 0; r < 4; r++)
            for (int t = 0; t < THREADS; t++) step(50 + 10 * t, "R9");
        do_reset("R9");
        for (int r = 0; r < 2; r++)
            for (int t = 0; t < THREADS; t++) step((t == 0) ? 5 : 0, "R9");
    endtask

    initial begin
        rst = 1'b1;
        in_sample = '0;
        model_clear();
        @(negedge clk);
        test_reset_state();
        test_patterns();
        test_large();
        test_boundary();
        test_hold();
        test_independence();
        test_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule